// File: doc/BRIEF.md
# Four-State Vector Arithmetic Unit

This unit adds, subtracts or multiplies two equal-width vectors in which every logic bit can be 0, 1, z or x. Each bit is carried on the wire as a two-bit code. The right operand can be swapped for a 16-bit immediate. The immediate is zero-extended and never holds x or z. The result has the operand width, so the carry out of the top bit and the upper half of a product are dropped.

A start pulse captures the inputs. The result appears in a register on the next clock, with a one-cycle done strobe. If either operand in use holds any x or z bit, every bit of the result becomes x. Between start pulses the result holds its value. The unit sits next to an operand-fetch stage, which drives the vectors and the op code, and a write-back stage, which takes the result when done is high.

Top module: `fsv_arith`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), res_out holds code 00 in every bit position and done is low.
- R2: Logic bit i of every vector sits in bits [2i+1:2i], coded as 00 for 0, 01 for 1, 10 for z and 11 for x. A known result uses only 00 and 01.
- R3: op_sel 00 gives the sum of the two operands modulo 2^W.
- R4: op_sel 01 gives the left operand plus the ones' complement of the right operand plus one, modulo 2^W. For example, 0 minus 1 gives all ones.
- R5: op_sel 10 gives the low W bits of the product of the two operands.
- R6: When use_imm is 1, the 16-bit imm input, zero-extended, replaces the right operand. rhs_in, including any x or z bits in it, then has no effect on the result.
- R7: If any bit of the left operand, or of rhs_in when use_imm is 0, is z or x, every bit of the result is x (code 11).
- R8: op_sel 11 is not a defined operation and yields an all-x result.
- R9: The clock edge that samples start high loads the result into res_out and drives done high for that one cycle. done is low in every cycle that does not follow a start.
- R10: While start is low, res_out keeps its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture the inputs and compute on this edge |
| op_sel | input | 2 | 00 add, 01 subtract, 10 multiply, 11 undefined |
| use_imm | input | 1 | Replace the right operand with imm |
| lhs_in | input | 2*W | Left operand, four-state coded |
| rhs_in | input | 2*W | Right operand, four-state coded |
| imm | input | 16 | Immediate, binary, zero-extended |
| res_out | output | 2*W | Registered four-state result |
| done | output | 1 | One-cycle strobe when res_out is updated |

## Verification
The add, subtract and multiply paths are each given small operands and operands that wrap, such as all-ones plus one, zero minus one, and a product that overflows. These show whether the carry and the upper product bits are correctly dropped. Single z or x bits are placed at the low end and at the high end of each operand. This tells a true whole-vector poison apart from a poison that only covers part of the vector or only one operand. Immediate forms are driven with rhs_in full of x, which tells apart a design that really ignores the right vector from one that only muxes its value. Back-to-back starts and idle cycles with changing inputs separate the capture timing from the hold behaviour.

// File: rtl/fsv_pkg.sv
// Shared types for the four-state arithmetic unit.
// Assumes the two-bit bit code: 00=0, 01=1, 10=z, 11=x.
package fsv_pkg;
    typedef enum logic [1:0] {
        FSV_ADD = 2'b00,
        FSV_SUB = 2'b01,
        FSV_MUL = 2'b10,
        FSV_RSV = 2'b11
    } fsv_op_e;

    localparam logic [1:0] CODE_X = 2'b11;
endpackage

// File: rtl/fsv_unpack.sv
// Splits a four-state coded vector into its binary value bits and one
// flag that is set when any bit is z or x.
// Assumes: the upper bit of each code pair marks a z or x bit.
module fsv_unpack #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] code,
    output logic [W-1:0]   val,
    output logic           unk
);
    logic [W-1:0] flag;

    // One slice for each bit: the value bit and the unknown marker.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign val[i]  = code[2*i];
        assign flag[i] = code[2*i+1];
    end

    // Any marked bit poisons the whole vector.
    assign unk = |flag;
endmodule

// File: rtl/fsv_alu.sv
// Binary add, subtract and multiply at width W. Carry and upper product
// bits are dropped.
// Assumes: the operands are already free of z and x.
module fsv_alu
    import fsv_pkg::*;
#(
    parameter int W = 32
) (
    input  fsv_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic           inv_b;
    logic [W-1:0]   b_add;
    logic [W-1:0]   sum;
    logic [W-1:0]   prod;

    // Subtract is an add of the inverted right operand with carry-in one.
    assign inv_b = (op == FSV_SUB);
    assign b_add = inv_b ? ~b : b;
    assign sum   = a + b_add + {{(W-1){1'b0}}, inv_b};
    assign prod  = a * b;

    // Result select.
    always_comb begin
        case (op)
            FSV_MUL: y = prod;
            default: y = sum;
        endcase
    end
endmodule

// File: rtl/fsv_pack.sv
// Turns a binary vector back into four-state codes. When poison is set,
// every bit is forced to x.
// Assumes: val carries no unknowns.
module fsv_pack
    import fsv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]   val,
    input  logic           poison,
    output logic [2*W-1:0] code
);
    // One code pair for each bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign code[2*i+1 -: 2] = poison ? CODE_X : {1'b0, val[i]};
    end
endmodule

// File: rtl/fsv_arith.sv
// Four-state vector arithmetic unit. It decodes both operands, swaps in a
// zero-extended immediate when asked, computes add, subtract or multiply,
// poisons the result to x on any z or x input, and registers the result
// with a one-cycle done strobe.
// Assumes: a synchronous active-low reset and IMM_W no larger than W.
module fsv_arith
    import fsv_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op_sel,
    input  logic             use_imm,
    input  logic [2*W-1:0]   lhs_in,
    input  logic [2*W-1:0]   rhs_in,
    input  logic [IMM_W-1:0] imm,
    output logic [2*W-1:0]   res_out,
    output logic             done
);
    localparam int CW = 2 * W;

    fsv_op_e        op_e;
    logic [W-1:0]   lhs_val, rhs_val, imm_ext, b_val, y_val;
    logic           lhs_unk, rhs_unk, poison;
    logic [CW-1:0]  next_code;
    logic [CW-1:0]  hi_mask;

    assign op_e = fsv_op_e'(op_sel);

    fsv_unpack #(.W(W)) u_lhs (.code(lhs_in), .val(lhs_val), .unk(lhs_unk));
    fsv_unpack #(.W(W)) u_rhs (.code(rhs_in), .val(rhs_val), .unk(rhs_unk));

    // Zero-extend the immediate to the operand width.
    if (W > IMM_W) begin : g_ext
        assign imm_ext = {{(W-IMM_W){1'b0}}, imm};
    end else begin : g_noext
        assign imm_ext = imm[W-1:0];
    end

    // Choose the right operand. rhs flags only matter when it is used.
    assign b_val  = use_imm ? imm_ext : rhs_val;
    assign poison = lhs_unk | (rhs_unk & ~use_imm) | (op_e == FSV_RSV);

    fsv_alu #(.W(W)) u_alu (.op(op_e), .a(lhs_val), .b(b_val), .y(y_val));

    fsv_pack #(.W(W)) u_pack (.val(y_val), .poison(poison), .code(next_code));

    // Result register and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out <= '0;
            done    <= 1'b0;
        end else begin
            done <= start;
            if (start) res_out <= next_code;
        end
    end

    // Mask of the upper bit of every code pair.
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign hi_mask[2*i+1 -: 2] = 2'b10;
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R9
    AST_NO_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(res_out)); // R10
    AST_LHS_POISON: assert property (@(posedge clk) disable iff (!rst_n) (start && lhs_unk) |=> (res_out == '1)); // R7
    AST_RSV_ALL_X: assert property (@(posedge clk) disable iff (!rst_n) (start && op_sel == 2'b11) |=> (res_out == '1)); // R8
    AST_IMM_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (start && use_imm && !lhs_unk && op_sel != 2'b11) |=> ((res_out & hi_mask) == '0)); // R6
endmodule

// File: tb/sim_fsv_arith.sv
// Bench for fsv_arith. A behavioural reference model is compared with the
// outputs on every falling clock edge.
module sim_fsv_arith;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [1:0]    op_sel;
    logic          use_imm;
    logic [63:0]   lhs_in, rhs_in;
    logic [15:0]   imm;
    logic [63:0]   res_out;
    logic          done;

    int     checks = 0;
    int     errors = 0;
    int     cycles = 0;
    bit     live   = 1'b0;
    string  cur_req = "R1";

    logic [63:0] exp_res;
    logic        exp_done;

    always #5 clk = ~clk;

    fsv_arith #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .use_imm(use_imm), .lhs_in(lhs_in), .rhs_in(rhs_in), .imm(imm),
        .res_out(res_out), .done(done)
    );

    // Binary to four-state codes.
    function automatic logic [63:0] enc(input logic [31:0] v);
        logic [63:0] c = '0;
        for (int i = 0; i < 32; i++) c[2*i] = v[i];
        return c;
    endfunction

    // Reference model.
    function automatic logic [63:0] model(input logic [1:0] op, input logic ui,
                                          input logic [63:0] l, input logic [63:0] r,
                                          input logic [15:0] im);
        logic [31:0] a, b, y;
        bit unk = 0;
        for (int i = 0; i < 32; i++) begin
            a[i] = l[2*i];
            if (l[2*i+1]) unk = 1;
        end
        if (ui) b = {16'h0, im};
        else begin
            for (int i = 0; i < 32; i++) begin
                b[i] = r[2*i];
                if (r[2*i+1]) unk = 1;
            end
        end
        case (op)
            2'd0: y = a + b;
            2'd1: y = a - b;
            2'd2: y = a * b;
            default: begin y = '0; unk = 1; end
        endcase
        return unk ? {64{1'b1}} : enc(y);
    endfunction

    // Model state advances with the design clock.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            exp_res  <= '0;
            exp_done <= 1'b0;
        end else begin
            exp_done <= start;
            if (start) exp_res <= model(op_sel, use_imm, lhs_in, rhs_in, imm);
        end
    end

    // Compare on every falling edge once running.
    always @(negedge clk) begin
        if (live) begin
            checks++;
            if (res_out !== exp_res || done !== exp_done) begin
                errors++;
                $display("FAIL %s res=%h exp=%h done=%b exp_done=%b",
                         cur_req, res_out, exp_res, done, exp_done);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog res=%h exp=%h", res_out, exp_res);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic go(input string tag, input logic [1:0] op, input logic ui,
                      input logic [63:0] l, input logic [63:0] r, input logic [15:0] im);
        cur_req = tag;
        start = 1'b1; op_sel = op; use_imm = ui;
        lhs_in = l; rhs_in = r; imm = im;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        start = 1'b0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    logic [63:0] t;

    initial begin
        rst_n = 1'b0; start = 1'b0; op_sel = 2'b00; use_imm = 1'b0;
        lhs_in = enc(32'h1234); rhs_in = enc(32'h55); imm = 16'h0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state, explicitly checked
        checks++;
        if (res_out !== 64'h0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R1 res=%h exp=0 done=%b exp=0", res_out, done);
        end
        live = 1'b1;
        rst_n = 1'b1;
        idle(2);

        // R3 add, small and wrapping; R2 coding checked through model
        go("R3", 2'd0, 0, enc(32'd7), enc(32'd5), 16'h0); idle(1);
        go("R3", 2'd0, 0, enc(32'hFFFF_FFFF), enc(32'd1), 16'h0); idle(1);
        go("R2", 2'd0, 0, enc(32'hA5A5_0F0F), enc(32'h1111_2222), 16'h0); idle(1);
        // R4 subtract
        go("R4", 2'd1, 0, enc(32'd0), enc(32'd1), 16'h0); idle(1);
        go("R4", 2'd1, 0, enc(32'd1000), enc(32'd999), 16'h0); idle(1);
        // R5 multiply, with overflow
        go("R5", 2'd2, 0, enc(32'd12), enc(32'd13), 16'h0); idle(1);
        go("R5", 2'd2, 0, enc(32'h0001_0001), enc(32'hFFFF_0003), 16'h0); idle(1);
        // R6 immediate forms with rhs full of x
        go("R6", 2'd0, 1, enc(32'hFFFF_0000), {64{1'b1}}, 16'hFFFF); idle(1);
        go("R6", 2'd1, 1, enc(32'd3), {64{1'b1}}, 16'd5); idle(1);
        go("R6", 2'd2, 1, enc(32'h0002_0000), {64{1'b1}}, 16'h8001); idle(1);
        // R7 poison: z in lhs low, x in rhs high, z in lhs with immediate
        t = enc(32'd9); t[1:0] = 2'b10;
        go("R7", 2'd0, 0, t, enc(32'd1), 16'h0); idle(1);
        t = enc(32'd9); t[63:62] = 2'b11;
        go("R7", 2'd1, 0, enc(32'd4), t, 16'h0); idle(1);
        t = enc(32'd9); t[63:62] = 2'b10;
        go("R7", 2'd2, 1, t, enc(32'd1), 16'h3); idle(1);
        // R8 undefined op
        go("R8", 2'd3, 0, enc(32'd1), enc(32'd2), 16'h0); idle(1);
        // R9 back-to-back starts
        go("R9", 2'd0, 0, enc(32'd1), enc(32'd2), 16'h0);
        go("R9", 2'd2, 0, enc(32'd3), enc(32'd4), 16'h0);
        go("R9", 2'd1, 0, enc(32'd50), enc(32'd8), 16'h0);
        idle(2);
        // R10 inputs wiggle with start low
        cur_req = "R10";
        start = 1'b0;
        for (int k = 0; k < 6; k++) begin
            lhs_in = enc(32'h1000 * k); rhs_in = {64{k[0]}}; op_sel = k[1:0];
            @(posedge clk); #1;
        end
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule